// File: doc/BRIEF.md
# Stepper Phase Head Positioner

This block keeps track of where the read/write head of a floppy drive sits, working from the four coil magnets of its stepper motor. Firmware energizes one coil at a time by writing a coil index together with an on/off flag. The block keeps the resulting coil state, the coil that last pulled the head, and a head position counted in half-track steps.

On an evaluation strobe, while the motor is on, the block compares the coil now energized with the coil that last moved the head. The head moves one half-track inward when the new coil is the next one around the ring, and one outward when it is the previous one. A separate signed jog input moves the head by several steps at once, for initialisation and test. The position saturates at zero and at a parameterised maximum.

Top module: `head_stepper_tracker`

## Requirements
- R1: After reset `head_pos` is 0, `coil_state` is 0, and the remembered last coil is coil 0 (value 0x1). A first evaluation with coil 1 energized therefore moves the head inward.
- R2: A coil write with `coil_on`=1 replaces the whole of `coil_state` with the single bit `1 << coil_sel`, so index 0,1,2,3 gives 0x1,0x2,0x4,0x8. The new value shows on the clock edge that takes the write. Without a write, `coil_state` keeps its value.
- R3: A coil write with `coil_on`=0 clears `coil_state` to 0, whatever the index.
- R4: The ring order is 0x1, 0x2, 0x4, 0x8, then back to 0x1. On an evaluation with the motor on, a coil state one place after the last coil adds 1 to `head_pos`, and that state becomes the last coil. This includes the step from 0x8 to 0x1.
- R5: On an evaluation with the motor on, a coil state one place before the last coil subtracts 1 from `head_pos`, and that state becomes the last coil. This includes the step from 0x1 to 0x8.
- R6: On an evaluation, a coil state that equals the last coil, is zero, or lies two places away in the ring does not move the head and does not change the last coil.
- R7: While `motor_on` is 0, evaluation strobes have no effect on the position or on the last coil. Coil writes are still accepted.
- R8: A jog adds the signed `jog_delta` to the position. Every result, whether from a jog or from a coil step, is clamped to the range 0 to MAX_STEP, where MAX_STEP defaults to 69.
- R9: When a jog and an evaluation fall in the same cycle, both amounts are added before the clamp is applied. An evaluation uses the coil state held before any coil write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| motor_on | input | 1 | Drive online; gates evaluation |
| coil_wr | input | 1 | Coil write strobe |
| coil_sel | input | $clog2(PHASES) | Coil index for the write |
| coil_on | input | 1 | 1 energizes the selected coil, 0 clears all coils |
| eval_stb | input | 1 | Compare coil state with the last coil and step |
| jog_vld | input | 1 | Apply jog_delta this cycle |
| jog_delta | input | DELTA_W | Signed multi-step move |
| head_pos | output | $clog2(MAX_STEP+1) | Half-track position |
| coil_state | output | PHASES | One-hot (or zero) coil state |

## Verification
Two kinds of same-cycle overlap are tested. A jog and a ring step can land on the same edge, and an evaluation can land on the edge that also takes a coil write. The bench drives a jog of +3 together with an inward coil step and expects a net change of +4. It also drives a jog that, combined with a step, crosses the upper limit, and expects the result to clamp only after both amounts are added. It then writes a new coil in the same cycle as an evaluation and checks that the head moved according to the old coil, while the coil state already shows the new one.

// File: rtl/hstep_pkg.sv
package hstep_pkg;

   typedef enum logic [1:0] {
      MV_HOLD = 2'b00,
      MV_IN   = 2'b01,
      MV_OUT  = 2'b10
   } move_e;

endpackage

// File: rtl/hstep_coil_reg.sv
module hstep_coil_reg #(
   parameter int PHASES = 4,
   localparam int IW = (PHASES > 1) ? $clog2(PHASES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [IW-1:0]     sel,
   input  logic              on,
   output logic [PHASES-1:0] state
);

   logic [PHASES-1:0] nxt;

   for (genvar g = 0; g < PHASES; g++) begin : g_bit
      always_comb nxt[g] = on && (sel == IW'(g));
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         state <= '0;
      else if (wr)
         state <= nxt;
   end

endmodule

// File: rtl/hstep_ring_dir.sv
module hstep_ring_dir #(
   parameter int PHASES = 4
) (
   input  logic [PHASES-1:0] state,
   input  logic [PHASES-1:0] last,
   output hstep_pkg::move_e  mv
);
   import hstep_pkg::*;

   logic [PHASES-1:0] fwd_hit;
   logic [PHASES-1:0] bwd_hit;

   for (genvar g = 0; g < PHASES; g++) begin : g_cmp
      localparam int NX = (g + 1) % PHASES;
      always_comb begin
         fwd_hit[g] = last[g] & state[NX];
         bwd_hit[g] = last[NX] & state[g];
      end
   end

   always_comb begin
      if (|fwd_hit)
         mv = MV_IN;
      else if (|bwd_hit)
         mv = MV_OUT;
      else
         mv = MV_HOLD;
   end

endmodule

// File: rtl/hstep_pos_acc.sv
module hstep_pos_acc #(
   parameter int PHASES   = 4,
   parameter int MAX_STEP = 69,
   parameter int DELTA_W  = 8,
   localparam int PW = $clog2(MAX_STEP + 1),
   localparam int SW = ((PW > DELTA_W) ? PW : DELTA_W) + 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      adv_en,
   input  hstep_pkg::move_e          adv,
   input  logic                      jog_vld,
   input  logic signed [DELTA_W-1:0] jog_delta,
   input  logic [PHASES-1:0]         state,
   output logic [PW-1:0]             pos,
   output logic [PHASES-1:0]         last
);
   import hstep_pkg::*;

   localparam logic signed [SW-1:0] MAXS = SW'(MAX_STEP);
   localparam logic [PHASES-1:0]    LAST_RST = PHASES'(1);

   logic signed [SW-1:0] inc;
   logic signed [SW-1:0] jog_x;
   logic signed [SW-1:0] sum;
   logic [PW-1:0]        pos_nxt;
   logic                 moved;

   always_comb begin
      inc = '0;
      if (adv_en && adv == MV_IN)
         inc = SW'(1);
      else if (adv_en && adv == MV_OUT)
         inc = -SW'(1);
      jog_x = jog_vld ? SW'(jog_delta) : '0;
      sum   = $signed({{(SW - PW){1'b0}}, pos}) + jog_x + inc;
      if (sum < 0)
         pos_nxt = '0;
      else if (sum > MAXS)
         pos_nxt = PW'(MAX_STEP);
      else
         pos_nxt = sum[PW-1:0];
      moved = adv_en && (adv != MV_HOLD);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos  <= '0;
         last <= LAST_RST;
      end else begin
         pos <= pos_nxt;
         if (moved)
            last <= state;
      end
   end

endmodule

// File: rtl/head_stepper_tracker.sv
module head_stepper_tracker #(
   parameter int PHASES   = 4,
   parameter int MAX_STEP = 69,
   parameter int DELTA_W  = 8,
   localparam int IW = (PHASES > 1) ? $clog2(PHASES) : 1,
   localparam int PW = $clog2(MAX_STEP + 1)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      motor_on,
   input  logic                      coil_wr,
   input  logic [IW-1:0]             coil_sel,
   input  logic                      coil_on,
   input  logic                      eval_stb,
   input  logic                      jog_vld,
   input  logic signed [DELTA_W-1:0] jog_delta,
   output logic [PW-1:0]             head_pos,
   output logic [PHASES-1:0]         coil_state
);
   import hstep_pkg::*;

   if (PHASES < 3) begin : g_bad_phases
      $error("PHASES must be at least 3 for a direction to be decodable");
   end
   if (MAX_STEP < 1) begin : g_bad_max
      $error("MAX_STEP must be at least 1");
   end
   if (DELTA_W < 2) begin : g_bad_dw
      $error("DELTA_W must be at least 2");
   end

   move_e             mv;
   logic [PHASES-1:0] last_coil;

   hstep_coil_reg #(.PHASES(PHASES)) u_coil (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (coil_wr),
      .sel   (coil_sel),
      .on    (coil_on),
      .state (coil_state)
   );

   hstep_ring_dir #(.PHASES(PHASES)) u_dir (
      .state (coil_state),
      .last  (last_coil),
      .mv    (mv)
   );

   hstep_pos_acc #(
      .PHASES   (PHASES),
      .MAX_STEP (MAX_STEP),
      .DELTA_W  (DELTA_W)
   ) u_acc (
      .clk       (clk),
      .rst_n     (rst_n),
      .adv_en    (motor_on && eval_stb),
      .adv       (mv),
      .jog_vld   (jog_vld),
      .jog_delta (jog_delta),
      .state     (coil_state),
      .pos       (head_pos),
      .last      (last_coil)
   );

endmodule

// File: rtl/hstep_checker.sv
module hstep_checker #(
   parameter int PHASES   = 4,
   parameter int MAX_STEP = 69,
   parameter int DELTA_W  = 8,
   localparam int IW = (PHASES > 1) ? $clog2(PHASES) : 1,
   localparam int PW = $clog2(MAX_STEP + 1)
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      motor_on,
   input logic                      coil_wr,
   input logic [IW-1:0]             coil_sel,
   input logic                      coil_on,
   input logic                      eval_stb,
   input logic                      jog_vld,
   input logic [PW-1:0]             head_pos,
   input logic [PHASES-1:0]         coil_state,
   input logic [PHASES-1:0]         last_coil
);

   a_r2_onehot_write: assert property (@(posedge clk) disable iff (!rst_n)
      coil_wr && coil_on |=> coil_state == (PHASES'(1) << $past(coil_sel)));

   a_r2_state_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !coil_wr |=> $stable(coil_state));

   a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
      coil_wr && !coil_on |=> coil_state == '0);

   a_r7_offline_still: assert property (@(posedge clk) disable iff (!rst_n)
      !motor_on && !jog_vld |=> $stable(head_pos) && $stable(last_coil));

   a_r8_upper_bound: assert property (@(posedge clk) disable iff (!rst_n)
      int'(head_pos) <= MAX_STEP);

   a_r6_last_single: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(last_coil) == 1);

   a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      !jog_vld |=> (int'(head_pos) - int'($past(head_pos))) inside {-1, 0, 1});

   a_r6_no_eval_no_last: assert property (@(posedge clk) disable iff (!rst_n)
      !eval_stb |=> $stable(last_coil));

endmodule

bind head_stepper_tracker hstep_checker #(
   .PHASES   (PHASES),
   .MAX_STEP (MAX_STEP),
   .DELTA_W  (DELTA_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .motor_on   (motor_on),
   .coil_wr    (coil_wr),
   .coil_sel   (coil_sel),
   .coil_on    (coil_on),
   .eval_stb   (eval_stb),
   .jog_vld    (jog_vld),
   .head_pos   (head_pos),
   .coil_state (coil_state),
   .last_coil  (last_coil)
);

// File: tb/head_stepper_tracker_test.sv
module head_stepper_tracker_test;

   localparam int PHASES   = 4;
   localparam int MAX_STEP = 69;
   localparam int DELTA_W  = 8;
   localparam int IW       = 2;
   localparam int PW       = $clog2(MAX_STEP + 1);

   logic                      clk = 1'b0;
   logic                      rst_n = 1'b0;
   logic                      motor_on = 1'b0;
   logic                      coil_wr = 1'b0;
   logic [IW-1:0]             coil_sel = '0;
   logic                      coil_on = 1'b0;
   logic                      eval_stb = 1'b0;
   logic                      jog_vld = 1'b0;
   logic signed [DELTA_W-1:0] jog_delta = '0;
   logic [PW-1:0]             head_pos;
   logic [PHASES-1:0]         coil_state;

   head_stepper_tracker #(
      .PHASES(PHASES), .MAX_STEP(MAX_STEP), .DELTA_W(DELTA_W)
   ) uut (
      .clk(clk), .rst_n(rst_n), .motor_on(motor_on), .coil_wr(coil_wr),
      .coil_sel(coil_sel), .coil_on(coil_on), .eval_stb(eval_stb),
      .jog_vld(jog_vld), .jog_delta(jog_delta),
      .head_pos(head_pos), .coil_state(coil_state)
   );

   always #5 clk = ~clk;

   typedef struct {
      int    pos;
      int    st;
      string tag;
   } exp_t;

   exp_t sb[$];
   int   total = 0;
   int   bad = 0;
   bit   done = 0;

   // bench model
   int m_pos = 0;
   int m_st = 0;
   int m_last = 1;

   function automatic int rotl(int v);
      return ((v << 1) | (v >> 3)) & 4'hF;
   endfunction
   function automatic int rotr(int v);
      return ((v >> 1) | (v << 3)) & 4'hF;
   endfunction

   task automatic drive(input bit w, input int idx, input bit on, input bit ev,
                        input bit jv, input int d, input string tag);
      int step;
      int np;
      exp_t e;
      @(negedge clk);
      coil_wr = w; coil_sel = IW'(idx); coil_on = on;
      eval_stb = ev; jog_vld = jv; jog_delta = DELTA_W'(d);
      step = 0;
      if (ev && motor_on) begin
         if (m_st == rotl(m_last)) step = 1;
         else if (m_st == rotr(m_last)) step = -1;
      end
      np = m_pos + step + (jv ? d : 0);
      if (np < 0) np = 0;
      if (np > MAX_STEP) np = MAX_STEP;
      m_pos = np;
      if (step != 0) m_last = m_st;
      if (w) m_st = on ? (1 << idx) : 0;
      @(posedge clk);
      #1;
      coil_wr = 0; eval_stb = 0; jog_vld = 0;
      e.pos = m_pos; e.st = m_st; e.tag = tag;
      sb.push_back(e);
   endtask

   always @(negedge clk) begin
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         total++;
         if (int'(head_pos) != e.pos || int'(coil_state) != e.st) begin
            bad++;
            $display("FAIL %s: pos=%0d state=0x%0h expected pos=%0d state=0x%0h",
                     e.tag, head_pos, coil_state, e.pos, e.st);
         end
      end
   end

   task automatic finish_up();
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #200000;
      total++; bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      finish_up();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      total++;
      if (head_pos != 0 || coil_state != 0) begin
         bad++;
         $display("FAIL R1 reset: pos=%0d state=0x%0h expected pos=0 state=0x0",
                  head_pos, coil_state);
      end
      rst_n = 1;
      motor_on = 1;
      // R2 / R1: energize coil 1, first evaluation moves inward from last=0x1
      drive(1, 1, 1, 0, 0, 0, "R2 coil1 on");
      drive(0, 0, 0, 1, 0, 0, "R1 first eval inward");
      // R4 inward around the ring including wrap 0x8 -> 0x1
      drive(1, 2, 1, 0, 0, 0, "R2 coil2 on");
      drive(0, 0, 0, 1, 0, 0, "R4 inward 2->4");
      drive(1, 3, 1, 0, 0, 0, "R2 coil3 on");
      drive(0, 0, 0, 1, 0, 0, "R4 inward 4->8");
      drive(1, 0, 1, 0, 0, 0, "R2 coil0 on");
      drive(0, 0, 0, 1, 0, 0, "R4 inward wrap 8->1");
      // R5 outward wrap 0x1 -> 0x8
      drive(1, 3, 1, 0, 0, 0, "R2 coil3 again");
      drive(0, 0, 0, 1, 0, 0, "R5 outward wrap 1->8");
      drive(1, 2, 1, 0, 0, 0, "R2 coil2");
      drive(0, 0, 0, 1, 0, 0, "R5 outward 8->4");
      // R6 same, opposite, zero
      drive(0, 0, 0, 1, 0, 0, "R6 same coil no move");
      drive(1, 0, 1, 0, 0, 0, "R2 coil0 opposite");
      drive(0, 0, 0, 1, 0, 0, "R6 opposite no move");
      drive(1, 3, 1, 0, 0, 0, "R2 coil3");
      drive(0, 0, 0, 1, 0, 0, "R6 last kept so 4->8 inward");
      drive(1, 2, 0, 0, 0, 0, "R3 off clears");
      drive(0, 0, 0, 1, 0, 0, "R6 zero state no move");
      // R7 offline
      motor_on = 0;
      drive(1, 0, 1, 0, 0, 0, "R7 write accepted offline");
      drive(0, 0, 0, 1, 0, 0, "R7 eval ignored offline");
      motor_on = 1;
      drive(0, 0, 0, 1, 0, 0, "R7 eval after online");
      // R8 jogs and clamps
      drive(0, 0, 0, 0, 1, 100, "R8 jog clamps high");
      drive(1, 1, 1, 0, 0, 0, "R2 coil1");
      drive(0, 0, 0, 1, 0, 0, "R8 step at max clamps");
      drive(0, 0, 0, 0, 1, -128, "R8 jog clamps low");
      drive(0, 0, 0, 0, 1, -5, "R8 jog below zero");
      drive(0, 0, 0, 0, 1, 7, "R8 jog up");
      drive(0, 0, 0, 0, 1, -3, "R8 jog down");
      drive(1, 0, 1, 0, 0, 0, "R2 coil0");
      drive(0, 0, 0, 1, 0, 0, "R5 outward 2->1");
      // R9 overlaps
      drive(1, 1, 1, 0, 0, 0, "R2 coil1 setup");
      drive(0, 0, 0, 1, 1, 3, "R9 jog plus step");
      drive(1, 2, 1, 1, 0, 0, "R9 eval uses old state");
      drive(0, 0, 0, 1, 0, 0, "R9 new state steps next");
      drive(0, 0, 0, 0, 1, 60, "R8 jog near top");
      drive(1, 3, 1, 0, 0, 0, "R2 coil3 near top");
      drive(0, 0, 0, 1, 1, 1, "R9 jog plus step clamped");
      drive(0, 0, 0, 1, 1, -2, "R9 jog down with held step");
      repeat (3) @(negedge clk);
      finish_up();
   end

endmodule